// File: doc/BRIEF.md
# Bridge Initiator Termination Controller

This block drives the initiator side of a bus-to-bus bridge on the bus where the target sits. A launch request supplies a transaction descriptor: its kind, a starting address, the number of DWORDs held in the bridge's data buffer, a latency-timer reload value and the bus the cycle runs on. The block then asserts FRAME and waits for a target to claim the cycle with DEVSEL. It either carries the cycle through its data phases or gives up with a master abort.

Once data moves, the transaction kind sets the exit point. Some kinds end after a single DWORD. Prefetching reads stop at a line boundary. Buffered writes and bursts run until the buffer is drained. Multi-DWORD kinds also stop when the latency timer has run out and the grant has been taken away. A target's retry, disconnect or abort ends the cycle at once.

A posted write that the latency timer cuts short restarts by itself after one idle clock, at the next undelivered DWORD. A prefetching read cut short the same way is not restarted. Each finished transaction is reported with a one-clock completion strobe and a termination code. Master aborts also raise a per-bus status strobe, and on posted writes they flush the buffered data.

Top module: `bridge_init_term`

## Requirements
- R1: Clocks are counted from the first rising edge at which `frame_n` is low. If `devsel_n` is sampled low at any of edges 1 to DEVSEL_WIN (default 5), the cycle is claimed. If it is not, the cycle ends at edge DEVSEL_WIN with code 1 (master abort), and no data moves.
- R2: A master abort pulses `ma_pri_set` when `bus_sec` was 0 at launch and `ma_sec_set` when it was 1, in the same clock as `done`. No other termination pulses either strobe.
- R3: Kind 0 (delayed write) and kind 1 (non-prefetchable read) end with code 0 (normal) on the edge where the first DWORD transfers. A DWORD transfers on an edge where both `devsel_n` and `trdy_n` are low. Each transfer adds 4 to `cur_addr` and subtracts 1 from `rem_out`, saturating at 0.
- R4: Kind 2 (prefetchable read) ends with code 0 on the transfer that moves `cur_addr` onto a multiple of LINE_BYTES (default 64).
- R5: Kind 3 (posted write) and kind 4 (burst) end with code 0 on the transfer of the last buffered DWORD, that is, when `rem_out` reaches 0.
- R6: For kinds 2, 3 and 4, once the cycle is claimed, the cycle ends with code 5 (latency expiry) at the first edge where the timer is zero and `gnt_n` is high. The timer is loaded from `lat_init` at launch and decremented on each active edge. A completion by R4 or R5 on the same edge takes precedence. When `mwi` is 1 the latency rule is ignored.
- R7: A posted write ended by R6 raises `frame_n` for exactly one clock and then reasserts it without pulsing `done`. The restart resumes from the current `cur_addr` and `rem_out` and reloads the timer. A prefetchable read ended by R6 is reported through `done` and not restarted.
- R8: `stop_n` low on a claimed cycle ends it. With `devsel_n` high the code is 2 (target abort). With `devsel_n` low and `trdy_n` high the code is 3 (retry). With both low the code is 4 (disconnect), and that DWORD is counted as transferred.
- R9: A master abort on kind 3 pulses `flush` together with `done` and clears `rem_out` to 0. Master aborts on other kinds leave `rem_out` unchanged and do not pulse `flush`.
- R10: While `rst_n` is low, `frame_n` is high and `busy`, `done`, `ma_pri_set`, `ma_sec_set` and `flush` are low. This holds even when reset arrives in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch request, accepted when idle |
| kind | input | 3 | Transaction kind: 0 delayed write, 1 non-prefetchable read, 2 prefetchable read, 3 posted write, 4 burst |
| mwi | input | 1 | Memory-write-and-invalidate burst, exempt from latency expiry |
| bus_sec | input | 1 | 0: cycle runs on the primary bus, 1: on the secondary bus |
| start_addr | input | ADDR_W | Address of the first DWORD |
| dword_cnt | input | CNT_W | DWORDs available in the data buffer |
| lat_init | input | LAT_W | Latency-timer reload value |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| frame_n | output | 1 | Cycle framing, active low |
| busy | output | 1 | Transaction in progress |
| cur_addr | output | ADDR_W | Address of the next DWORD to transfer |
| rem_out | output | CNT_W | Buffered DWORDs not yet delivered |
| done | output | 1 | One-clock completion strobe |
| done_code | output | 3 | Termination code, valid with `done` |
| ma_pri_set | output | 1 | Master abort received on the primary bus |
| ma_sec_set | output | 1 | Master abort received on the secondary bus |
| flush | output | 1 | Posted data discarded after master abort |

## Verification
The bench builds the block with its default parameters. These are a 64-byte prefetch line, a five-clock claim window and 8-bit counters. With them, a read starting at 0x1F0 crosses a line after four DWORDs, and claims at clocks 5 and 6 fall on either side of the abort point. Latency reload values of 1 and 2 force expiry in the middle of a burst. The cases cover a posted write that restarts twice, a burst with the latency exemption set, every target-initiated ending, and a reset in the middle of a transaction.

// File: rtl/bitc_pkg.sv
package bitc_pkg;

   typedef enum logic [2:0] {
      K_DLY_WR = 3'd0,
      K_NP_RD  = 3'd1,
      K_PF_RD  = 3'd2,
      K_PST_WR = 3'd3,
      K_BURST  = 3'd4
   } kind_e;

   typedef enum logic [2:0] {
      T_NORMAL = 3'd0,
      T_MABORT = 3'd1,
      T_TABORT = 3'd2,
      T_RETRY  = 3'd3,
      T_DISC   = 3'd4,
      T_LATEXP = 3'd5
   } term_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ACT  = 2'd1,
      S_TURN = 2'd2
   } st_e;

endpackage

// File: rtl/bitc_devsel_win.sv
module bitc_devsel_win #(
   parameter int DEVSEL_WIN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic active,
   input  logic devsel_n,
   output logic claim,
   output logic expire
);
   localparam int CW = (DEVSEL_WIN > 1) ? $clog2(DEVSEL_WIN) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEVSEL_WIN - 1);

   logic [CW-1:0] cnt_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (arm) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (active && !seen_q) begin
         if (!devsel_n) seen_q <= 1'b1;
         else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign claim  = seen_q | ~devsel_n;
   assign expire = active & ~seen_q & devsel_n & (cnt_q == LAST);

endmodule

// File: rtl/bitc_lat_timer.sv
module bitc_lat_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] load_val,
   input  logic             active,
   output logic             expired
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/bitc_term_rules.sv
module bitc_term_rules
   import bitc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int LINE_W = 6
) (
   input  logic              active,
   input  kind_e             kind,
   input  logic              mwi,
   input  logic              claim,
   input  logic              expire,
   input  logic              devsel_n,
   input  logic              trdy_n,
   input  logic              stop_n,
   input  logic              gnt_n,
   input  logic              lat_exp,
   input  logic [CNT_W-1:0]  rem,
   input  logic [LINE_W-3:0] line_off,
   output logic              xfer,
   output logic              fin,
   output term_e             code,
   output logic              relaunch
);
   logic line_end, rem_one, stop_hit, kind_done, multi, lat_hit;

   assign line_end = &line_off;
   assign rem_one  = (rem == CNT_W'(1));

   always_comb begin
      xfer      = active & ~devsel_n & ~trdy_n;
      stop_hit  = active & ~stop_n & claim;
      kind_done = 1'b0;
      multi     = 1'b0;
      case (kind)
         K_DLY_WR, K_NP_RD: kind_done = xfer;
         K_PF_RD: begin
            kind_done = xfer & line_end;
            multi     = 1'b1;
         end
         K_PST_WR, K_BURST: begin
            kind_done = xfer & rem_one;
            multi     = 1'b1;
         end
         default: kind_done = 1'b0;
      endcase
      lat_hit = active & claim & multi & lat_exp & gnt_n & ~mwi;

      fin  = 1'b1;
      code = T_NORMAL;
      if (expire)                    code = T_MABORT;
      else if (stop_hit && devsel_n) code = T_TABORT;
      else if (stop_hit && trdy_n)   code = T_RETRY;
      else if (stop_hit)             code = T_DISC;
      else if (kind_done)            code = T_NORMAL;
      else if (lat_hit)              code = T_LATEXP;
      else                           fin  = 1'b0;

      relaunch = fin & (code == T_LATEXP) & (kind == K_PST_WR);
   end

endmodule

// File: rtl/bridge_init_term.sv
module bridge_init_term
   import bitc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 8,
   parameter int LAT_W      = 8,
   parameter int LINE_BYTES = 64,
   parameter int DEVSEL_WIN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        kind,
   input  logic              mwi,
   input  logic              bus_sec,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  dword_cnt,
   input  logic [LAT_W-1:0]  lat_init,
   input  logic              gnt_n,
   input  logic              devsel_n,
   input  logic              trdy_n,
   input  logic              stop_n,
   output logic              frame_n,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  rem_out,
   output logic              done,
   output logic [2:0]        done_code,
   output logic              ma_pri_set,
   output logic              ma_sec_set,
   output logic              flush
);
   localparam int LINE_W = $clog2(LINE_BYTES);

   generate
      if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 8");
      end
      if (LINE_W > ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for LINE_BYTES");
      end
      if (DEVSEL_WIN < 1) begin : g_bad_win
         $error("DEVSEL_WIN must be at least 1");
      end
      if (CNT_W < 1 || LAT_W < 1) begin : g_bad_cnt
         $error("counter widths must be positive");
      end
   endgenerate

   st_e              st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   kind_e            kind_q;
   logic             mwi_q, bus_q, relaunch_q;
   logic [LAT_W-1:0] lat_q;
   logic             frame_q, done_q, ma_pri_q, ma_sec_q, flush_q;
   term_e            code_q;

   logic             active, arm;
   logic [LAT_W-1:0] lat_load_val;
   logic             claim, expire, lat_exp;
   logic             xfer, fin, relaunch;
   term_e            code;

   assign active       = (st_q == S_ACT);
   assign arm          = ((st_q == S_IDLE) && start) || ((st_q == S_TURN) && relaunch_q);
   assign lat_load_val = (st_q == S_IDLE) ? lat_init : lat_q;

   bitc_devsel_win #(.DEVSEL_WIN(DEVSEL_WIN)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .active   (active),
      .devsel_n (devsel_n),
      .claim    (claim),
      .expire   (expire)
   );

   bitc_lat_timer #(.LAT_W(LAT_W)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (arm),
      .load_val (lat_load_val),
      .active   (active),
      .expired  (lat_exp)
   );

   bitc_term_rules #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_rules (
      .active   (active),
      .kind     (kind_q),
      .mwi      (mwi_q),
      .claim    (claim),
      .expire   (expire),
      .devsel_n (devsel_n),
      .trdy_n   (trdy_n),
      .stop_n   (stop_n),
      .gnt_n    (gnt_n),
      .lat_exp  (lat_exp),
      .rem      (rem_q),
      .line_off (addr_q[LINE_W-1:2]),
      .xfer     (xfer),
      .fin      (fin),
      .code     (code),
      .relaunch (relaunch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         addr_q     <= '0;
         rem_q      <= '0;
         kind_q     <= K_DLY_WR;
         mwi_q      <= 1'b0;
         bus_q      <= 1'b0;
         lat_q      <= '0;
         relaunch_q <= 1'b0;
         frame_q    <= 1'b1;
         done_q     <= 1'b0;
         code_q     <= T_NORMAL;
         ma_pri_q   <= 1'b0;
         ma_sec_q   <= 1'b0;
         flush_q    <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         ma_pri_q <= 1'b0;
         ma_sec_q <= 1'b0;
         flush_q  <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  addr_q  <= start_addr;
                  rem_q   <= dword_cnt;
                  kind_q  <= kind_e'(kind);
                  mwi_q   <= mwi;
                  bus_q   <= bus_sec;
                  lat_q   <= lat_init;
                  frame_q <= 1'b0;
                  st_q    <= S_ACT;
               end
            end
            S_ACT: begin
               if (xfer) begin
                  addr_q <= addr_q + ADDR_W'(4);
                  if (rem_q != '0) rem_q <= rem_q - 1'b1;
               end
               if (fin) begin
                  frame_q    <= 1'b1;
                  st_q       <= S_TURN;
                  relaunch_q <= relaunch;
                  if (!relaunch) begin
                     done_q <= 1'b1;
                     code_q <= code;
                  end
                  if (code == T_MABORT) begin
                     ma_pri_q <= ~bus_q;
                     ma_sec_q <= bus_q;
                     if (kind_q == K_PST_WR) begin
                        flush_q <= 1'b1;
                        rem_q   <= '0;
                     end
                  end
               end
            end
            S_TURN: begin
               if (relaunch_q) begin
                  relaunch_q <= 1'b0;
                  frame_q    <= 1'b0;
                  st_q       <= S_ACT;
               end else begin
                  st_q <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign frame_n    = frame_q;
   assign busy       = (st_q != S_IDLE);
   assign cur_addr   = addr_q;
   assign rem_out    = rem_q;
   assign done       = done_q;
   assign done_code  = code_q;
   assign ma_pri_set = ma_pri_q;
   assign ma_sec_set = ma_sec_q;
   assign flush      = flush_q;

endmodule

// File: rtl/bridge_init_term_chk.sv
module bridge_init_term_chk
   import bitc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 8,
   parameter int DEVSEL_WIN = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              devsel_n,
   input logic              busy,
   input logic              done,
   input logic [2:0]        done_code,
   input logic              ma_pri_set,
   input logic              ma_sec_set,
   input logic              flush,
   input logic [CNT_W-1:0]  rem_out,
   input logic [ADDR_W-1:0] cur_addr
);
   localparam int NW = $clog2(DEVSEL_WIN + 1) + 1;

   logic [NW-1:0] nod_cnt;
   logic          seen_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nod_cnt <= '0;
         seen_c  <= 1'b0;
      end else if (frame_n) begin
         nod_cnt <= '0;
         seen_c  <= 1'b0;
      end else if (!seen_c) begin
         if (!devsel_n) seen_c <= 1'b1;
         else if (nod_cnt != '1) nod_cnt <= nod_cnt + 1'b1;
      end
   end

   p_abort_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code == T_MABORT) |-> (nod_cnt == NW'(DEVSEL_WIN) && !seen_c));

   p_claim_before_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code != T_MABORT) |-> seen_c);

   p_ma_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ma_pri_set || ma_sec_set) |-> (done && done_code == T_MABORT));

   p_ma_onebus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ma_pri_set, ma_sec_set}));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && $past(!frame_n)) |->
      (cur_addr == $past(cur_addr) || cur_addr == $past(cur_addr) + ADDR_W'(4)));

   p_relaunch_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(frame_n) && !done) |=> !frame_n);

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (done && done_code == T_MABORT && rem_out == '0));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (frame_n && busy));

endmodule

bind bridge_init_term bridge_init_term_chk #(
   .ADDR_W     (ADDR_W),
   .CNT_W      (CNT_W),
   .DEVSEL_WIN (DEVSEL_WIN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_n    (frame_n),
   .devsel_n   (devsel_n),
   .busy       (busy),
   .done       (done),
   .done_code  (done_code),
   .ma_pri_set (ma_pri_set),
   .ma_sec_set (ma_sec_set),
   .flush      (flush),
   .rem_out    (rem_out),
   .cur_addr   (cur_addr)
);

// File: tb/bridge_init_term_test.sv
module bridge_init_term_test;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;
   localparam int NV         = 14;

   typedef struct packed {
      logic [2:0]  kind;
      logic        mwi;
      logic        bus;
      logic [31:0] addr;
      logic [7:0]  cnt;
      logic [7:0]  lat;
      logic [3:0]  dev_e;
      logic [3:0]  trdy_e;
      logic [3:0]  stop_e;
      logic        tab;
      logic        gnt_hi;
      logic [2:0]  exp_code;
      logic [31:0] exp_addr;
      logic [7:0]  exp_rem;
      logic [3:0]  exp_rel;
      logic [1:0]  exp_ma;
      logic        exp_flush;
      logic [31:0] exp_raddr;
   } vec_t;

   // kind mwi bus addr cnt lat dev trdy stop tab gnt | code addr rem rel ma{pri,sec} flush raddr
   localparam vec_t TBL [NV] = '{
      '{3'd0,1'b0,1'b0,32'h100,8'd1, 8'd200,4'd2,4'd3,4'd0,1'b0,1'b0, 3'd0,32'h104,8'd0, 4'd0,2'b00,1'b0,32'h0},   // R3 delayed write
      '{3'd1,1'b0,1'b0,32'h180,8'd1, 8'd200,4'd1,4'd1,4'd0,1'b0,1'b0, 3'd0,32'h184,8'd0, 4'd0,2'b00,1'b0,32'h0},   // R3 non-prefetch read
      '{3'd3,1'b0,1'b1,32'h200,8'd4, 8'd200,4'd0,4'd0,4'd0,1'b0,1'b0, 3'd1,32'h200,8'd0, 4'd0,2'b01,1'b1,32'h0},   // R1 R2 R9 posted MA
      '{3'd0,1'b0,1'b0,32'hA00,8'd1, 8'd200,4'd5,4'd5,4'd0,1'b0,1'b0, 3'd0,32'hA04,8'd0, 4'd0,2'b00,1'b0,32'h0},   // R1 claim at edge 5
      '{3'd2,1'b0,1'b0,32'h1F0,8'd16,8'd200,4'd1,4'd1,4'd0,1'b0,1'b0, 3'd0,32'h200,8'd12,4'd0,2'b00,1'b0,32'h0},   // R4 line boundary
      '{3'd2,1'b0,1'b0,32'h100,8'd16,8'd2,  4'd1,4'd1,4'd0,1'b0,1'b1, 3'd5,32'h10C,8'd13,4'd0,2'b00,1'b0,32'h0},   // R6 R7 prefetch not reissued
      '{3'd3,1'b0,1'b0,32'h300,8'd5, 8'd1,  4'd1,4'd1,4'd0,1'b0,1'b1, 3'd0,32'h314,8'd0, 4'd2,2'b00,1'b0,32'h308}, // R7 relaunch
      '{3'd4,1'b1,1'b0,32'h400,8'd3, 8'd1,  4'd1,4'd1,4'd0,1'b0,1'b1, 3'd0,32'h40C,8'd0, 4'd0,2'b00,1'b0,32'h0},   // R5 R6 mwi exempt
      '{3'd4,1'b0,1'b0,32'h400,8'd3, 8'd1,  4'd1,4'd1,4'd0,1'b0,1'b1, 3'd5,32'h408,8'd1, 4'd0,2'b00,1'b0,32'h0},   // R6 burst expiry
      '{3'd1,1'b0,1'b0,32'h500,8'd1, 8'd200,4'd1,4'd0,4'd2,1'b0,1'b0, 3'd3,32'h500,8'd1, 4'd0,2'b00,1'b0,32'h0},   // R8 retry
      '{3'd3,1'b0,1'b0,32'h600,8'd4, 8'd200,4'd1,4'd1,4'd2,1'b0,1'b0, 3'd4,32'h608,8'd2, 4'd0,2'b00,1'b0,32'h0},   // R8 disconnect
      '{3'd0,1'b0,1'b0,32'h700,8'd1, 8'd200,4'd1,4'd0,4'd3,1'b1,1'b0, 3'd2,32'h700,8'd1, 4'd0,2'b00,1'b0,32'h0},   // R8 target abort
      '{3'd1,1'b0,1'b0,32'h800,8'd1, 8'd200,4'd0,4'd0,4'd0,1'b0,1'b0, 3'd1,32'h800,8'd1, 4'd0,2'b10,1'b0,32'h0},   // R2 R9 primary MA, no flush
      '{3'd0,1'b0,1'b1,32'h900,8'd1, 8'd200,4'd6,4'd6,4'd0,1'b0,1'b0, 3'd1,32'h900,8'd1, 4'd0,2'b01,1'b0,32'h0}    // R1 claim at edge 6 too late
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  kind = '0;
   logic        mwi = 1'b0;
   logic        bus_sec = 1'b0;
   logic [31:0] start_addr = '0;
   logic [7:0]  dword_cnt = '0;
   logic [7:0]  lat_init = '0;
   logic        gnt_n = 1'b0;
   logic        devsel_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic        stop_n = 1'b1;
   logic        frame_n, busy, done, ma_pri_set, ma_sec_set, flush;
   logic [31:0] cur_addr;
   logic [7:0]  rem_out;
   logic [2:0]  done_code;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bridge_init_term uut (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .mwi(mwi),
      .bus_sec(bus_sec), .start_addr(start_addr), .dword_cnt(dword_cnt),
      .lat_init(lat_init), .gnt_n(gnt_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
      .stop_n(stop_n), .frame_n(frame_n), .busy(busy), .cur_addr(cur_addr),
      .rem_out(rem_out), .done(done), .done_code(done_code),
      .ma_pri_set(ma_pri_set), .ma_sec_set(ma_sec_set), .flush(flush)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input int idx);
      vec_t v;
      int   k, falls;
      logic prev_f, got_done, gp, gs, gf;
      logic [31:0] raddr;
      v = TBL[idx];
      k = 0; falls = 0; prev_f = 1'b1; got_done = 1'b0;
      gp = 1'b0; gs = 1'b0; gf = 1'b0; raddr = '0;
      @(negedge clk);
      kind = v.kind; mwi = v.mwi; bus_sec = v.bus; start_addr = v.addr;
      dword_cnt = v.cnt; lat_init = v.lat; gnt_n = v.gnt_hi;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int it = 0; it < 200; it++) begin
         if (done) begin
            got_done = 1'b1;
            gp = ma_pri_set; gs = ma_sec_set; gf = flush;
            break;
         end
         if (!frame_n) begin
            if (prev_f) begin
               falls++;
               k = 0;
               if (falls == 2) raddr = cur_addr;
            end
            k++;
            devsel_n = !(v.dev_e != 0 && k >= int'(v.dev_e) &&
                         !(v.tab && v.stop_e != 0 && k >= int'(v.stop_e)));
            trdy_n   = !(v.trdy_e != 0 && k >= int'(v.trdy_e));
            stop_n   = !(v.stop_e != 0 && k >= int'(v.stop_e));
         end else begin
            devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
         end
         prev_f = frame_n;
         @(negedge clk);
      end
      devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; gnt_n = 1'b0;
      chk($sformatf("R3 vec%0d", idx), "done seen", {31'd0, got_done}, 32'd1);
      chk($sformatf("R8 vec%0d", idx), "done_code", {29'd0, done_code}, {29'd0, v.exp_code});
      chk($sformatf("R4 vec%0d", idx), "cur_addr", cur_addr, v.exp_addr);
      chk($sformatf("R5 vec%0d", idx), "rem_out", {24'd0, rem_out}, {24'd0, v.exp_rem});
      chk($sformatf("R7 vec%0d", idx), "relaunches", falls - 1, {28'd0, v.exp_rel});
      chk($sformatf("R2 vec%0d", idx), "ma strobes", {30'd0, gp, gs}, {30'd0, v.exp_ma});
      chk($sformatf("R9 vec%0d", idx), "flush", {31'd0, gf}, {31'd0, v.exp_flush});
      if (v.exp_rel != 0)
         chk($sformatf("R7 vec%0d", idx), "relaunch addr", raddr, v.exp_raddr);
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", WD_CYCLES, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "frame_n in reset", {31'd0, frame_n}, 32'd1);
      chk("R10", "busy in reset", {31'd0, busy}, 32'd0);
      chk("R10", "strobes in reset", {28'd0, done, ma_pri_set, ma_sec_set, flush}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle after reset", {30'd0, frame_n, busy}, 32'b10);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R10: reset in the middle of an unclaimed posted write
      @(negedge clk);
      @(negedge clk);
      kind = 3'd3; start_addr = 32'hB00; dword_cnt = 8'd4; lat_init = 8'd50;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "frame asserted before reset", {31'd0, frame_n}, 32'd0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10", "frame_n after mid reset", {31'd0, frame_n}, 32'd1);
      chk("R10", "busy after mid reset", {31'd0, busy}, 32'd0);
      chk("R10", "strobes after mid reset", {28'd0, done, ma_pri_set, ma_sec_set, flush}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R1", "no abort after reset", {30'd0, frame_n, done}, 32'b10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule